// File: doc/BRIEF.md
# Holdover Tuning-Word Controller

This block chooses the frequency control word that steers a digitally controlled oscillator inside a digital PLL. While the reference is present it passes the loop-filter output through. It also averages that output over fixed windows to build a tuning word history. When the reference disappears it switches to a holdover word and keeps it constant until a reference returns.

The holdover word comes from one of three sources. If a completed history average exists, the block uses that average. Without history, a mode input picks either the programmed free-run word or the last loop-filter word, held frozen. The block also drives two flags. The loss-of-phase-lock flag is set whenever the loop is not locked. The loss-of-frequency-lock flag compares an external frequency-error magnitude against a programmable threshold. When the reference returns, the block goes back to acquisition and pulses a seed strobe so that the loop filter resumes from the word being output, with no jump.

The phase detector, the loop-filter arithmetic and the oscillator are outside the block. The `phase_locked` input and the `freq_err` magnitude come from the surrounding loop.

Top module: `dpll_holdover_ctrl`

## Requirements
- R1: After reset, the state output is FREE_RUN (code 0). The control word equals `freerun_word`, both lock-loss flags are 1 and `hist_valid` is 0.
- R2: State codes are FREE_RUN=0, ACQUIRE=1, LOCKED=2 and HOLDOVER=3. FREE_RUN goes to ACQUIRE one cycle after `ref_ok` is high. ACQUIRE goes to LOCKED while `ref_ok` and `phase_locked` are high. LOCKED falls back to ACQUIRE when `phase_locked` drops. HOLDOVER is entered only from ACQUIRE or LOCKED, one cycle after `ref_ok` is low.
- R3: If `hist_valid` is 1 at holdover entry, the holdover word is the most recent completed history average, whatever `hold_mode` is.
- R4: If history is not valid and `hold_mode` is 0, the holdover word is `freerun_word` as sampled at entry. Later changes of `freerun_word` do not alter it.
- R5: If history is not valid and `hold_mode` is 1, the holdover word is the last loop-filter word that was accepted before entry.
- R6: `lopl` is 1 in every state except LOCKED, so it is 1 from the first HOLDOVER cycle onward.
- R7: `lofl` is 1 in FREE_RUN. In every other state it is 1 exactly when `freq_err` is strictly greater than `lofl_thresh`.
- R8: In HOLDOVER, `ref_ok` high moves the block to ACQUIRE on the next cycle. The control word in that first ACQUIRE cycle equals the holdover word, and `lf_seed` is high for exactly that one cycle. The same seeding happens on the step from FREE_RUN to ACQUIRE.
- R9: A loop-filter word is accepted only when `lf_valid` is high in ACQUIRE or LOCKED with `ref_ok` high. In those states the control word is the last accepted or seeded word. Words offered in FREE_RUN or HOLDOVER have no effect.
- R10: The history average is the sum of 2^K consecutive words accepted in LOCKED, shifted right by K (truncated). `hist_valid` rises on the cycle after the last word of the first full window. Words accepted in ACQUIRE do not count, and a partial window is discarded when LOCKED is left.
- R11: During HOLDOVER the control word and the history are frozen. `hist_valid`, once set, stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_word | input | W | Loop-filter output word |
| lf_valid | input | 1 | Strobe qualifying `lf_word` |
| ref_ok | input | 1 | A valid reference is available |
| phase_locked | input | 1 | Loop reports phase lock |
| freerun_word | input | W | Programmed free-run tuning word |
| hold_mode | input | 1 | No-history holdover source: 0 free-run word, 1 frozen loop-filter word |
| freq_err | input | EW | Frequency-error magnitude |
| lofl_thresh | input | EW | Loss-of-frequency-lock threshold |
| dco_word | output | W | Selected oscillator control word |
| op_state | output | 2 | Current state code |
| lopl | output | 1 | Loss-of-phase-lock flag |
| lofl | output | 1 | Loss-of-frequency-lock flag |
| hist_valid | output | 1 | A completed history average exists |
| lf_seed | output | 1 | Loop-filter reload strobe; seed value is `dco_word` |

## Verification
The bench enters holdover three times: without history in each mode, and again with history present.

- A design that ignored `hist_valid` or `hold_mode` would output the wrong one of the three words.
- If it followed `freerun_word` live, the word would change mid-holdover.
- If it kept accepting loop-filter strobes in holdover, the frozen word would drift.

Windows are driven so that the partial-window and ACQUIRE-phase samples would corrupt the average if they were counted. The bench compares each resulting average against the truncated mean.

The frequency-lock threshold is probed at equality and one above, which catches a `>=` versus `>` slip. Each exit from holdover is checked for an output jump and for a missing or doubled seed strobe.

// File: rtl/dpll_holdover_ctrl.sv
module dpll_holdover_ctrl #(
  parameter int W  = 24,
  parameter int K  = 6,
  parameter int EW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  lf_word,
  input  logic          lf_valid,
  input  logic          ref_ok,
  input  logic          phase_locked,
  input  logic [W-1:0]  freerun_word,
  input  logic          hold_mode,
  input  logic [EW-1:0] freq_err,
  input  logic [EW-1:0] lofl_thresh,
  output logic [W-1:0]  dco_word,
  output logic [1:0]    op_state,
  output logic          lopl,
  output logic          lofl,
  output logic          hist_valid,
  output logic          lf_seed
);
  localparam int AW = W + K;
  localparam logic [1:0] S_FREE = 2'd0, S_ACQ = 2'd1, S_LOCK = 2'd2, S_HOLD = 2'd3;

  logic [1:0]    state, nxt;
  logic [W-1:0]  lf_last, hold_word, hist_avg;
  logic [AW-1:0] acc, sum_next;
  logic [K-1:0]  cnt;
  logic          take, seeding, entering_hold;

  always_comb begin
    nxt = state;
    case (state)
      S_FREE: if (ref_ok) nxt = S_ACQ;
      S_ACQ:  if (!ref_ok) nxt = S_HOLD; else if (phase_locked) nxt = S_LOCK;
      S_LOCK: if (!ref_ok) nxt = S_HOLD; else if (!phase_locked) nxt = S_ACQ;
      default: if (ref_ok) nxt = S_ACQ;
    endcase
  end

  assign take          = lf_valid && ref_ok && (state == S_ACQ || state == S_LOCK);
  assign seeding       = (nxt == S_ACQ) && (state == S_FREE || state == S_HOLD);
  assign entering_hold = (nxt == S_HOLD) && (state != S_HOLD);
  assign sum_next      = acc + {{K{1'b0}}, lf_word};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_FREE;
      lf_last    <= '0;
      hold_word  <= '0;
      hist_avg   <= '0;
      hist_valid <= 1'b0;
      acc        <= '0;
      cnt        <= '0;
      lf_seed    <= 1'b0;
    end else begin
      state   <= nxt;
      lf_seed <= seeding;
      if (seeding) lf_last <= dco_word;
      else if (take) lf_last <= lf_word;
      if (entering_hold)
        hold_word <= hist_valid ? hist_avg : (hold_mode ? lf_last : freerun_word);
      if (state != S_LOCK) begin
        acc <= '0;
        cnt <= '0;
      end else if (take) begin
        if (&cnt) begin
          hist_avg   <= sum_next[AW-1:K];
          hist_valid <= 1'b1;
          acc        <= '0;
          cnt        <= '0;
        end else begin
          acc <= sum_next;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign dco_word = (state == S_FREE) ? freerun_word :
                    (state == S_HOLD) ? hold_word : lf_last;
  assign op_state = state;
  assign lopl     = (state != S_LOCK);
  assign lofl     = (state == S_FREE) || (freq_err > lofl_thresh);

  assert_hold_entry_needs_lor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && $past(state) != S_HOLD) |-> (!$past(ref_ok) && $past(state) != S_FREE));

  assert_exit_no_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACQ && $past(state) == S_HOLD) |-> (dco_word == $past(dco_word) && lf_seed));

  assert_seed_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lf_seed |=> !lf_seed);

  assert_hold_word_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && $past(state) == S_HOLD) |-> $stable(dco_word));

  assert_hist_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && $past(state) == S_HOLD) |-> ($stable(hist_avg) && $stable(hist_valid)));

  assert_hist_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hist_valid |=> hist_valid);

  assert_hold_lopl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt == S_HOLD) |=> lopl);
endmodule

// File: tb/dpll_holdover_ctrl_test.sv
module dpll_holdover_ctrl_test;
  localparam int W = 16, K = 2, EW = 8;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] lf_word = '0, freerun_word = 16'h1000;
  logic lf_valid = 0, ref_ok = 0, phase_locked = 0, hold_mode = 0;
  logic [EW-1:0] freq_err = '0, lofl_thresh = 8'd20;
  logic [W-1:0] dco_word;
  logic [1:0] op_state;
  logic lopl, lofl, hist_valid, lf_seed;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dpll_holdover_ctrl #(.W(W), .K(K), .EW(EW)) uut (
    .clk(clk), .rst_n(rst_n), .lf_word(lf_word), .lf_valid(lf_valid), .ref_ok(ref_ok),
    .phase_locked(phase_locked), .freerun_word(freerun_word), .hold_mode(hold_mode),
    .freq_err(freq_err), .lofl_thresh(lofl_thresh), .dco_word(dco_word),
    .op_state(op_state), .lopl(lopl), .lofl(lofl), .hist_valid(hist_valid), .lf_seed(lf_seed));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sample(logic [W-1:0] v);
    lf_word = v; lf_valid = 1; tick(); lf_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ref_ok = 0; phase_locked = 0; hold_mode = 0; lf_valid = 0;
    freerun_word = 16'h1000; freq_err = 0;
    tick(); tick(); rst_n = 1; tick();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 state", op_state, 0); check("R1 word", dco_word, 16'h1000);
    check("R1 lopl", lopl, 1); check("R1 lofl", lofl, 1); check("R1 hist", hist_valid, 0);
    sample(16'h0055);
    check("R9 ignored in free-run", dco_word, 16'h1000);
  endtask

  task automatic t_acquire();
    ref_ok = 1; tick();
    check("R2 to acquire", op_state, 1); check("R8 seed pulse", lf_seed, 1);
    check("R8 seed word", dco_word, 16'h1000);
    tick(); check("R8 seed one cycle", lf_seed, 0);
    sample(16'h1200); check("R9 follow lf", dco_word, 16'h1200);
    for (int i = 0; i < 4; i++) sample(16'h1200);
    check("R10 acquire not counted", hist_valid, 0);
    phase_locked = 1; tick();
    check("R2 to locked", op_state, 2); check("R6 lopl locked", lopl, 0);
  endtask

  task automatic t_hold_mode0();
    sample(16'h1300); sample(16'h1304);
    ref_ok = 0; tick();
    check("R2 to holdover", op_state, 3); check("R6 lopl holdover", lopl, 1);
    check("R10 partial discarded", hist_valid, 0);
    check("R4 free-run word", dco_word, 16'h1000);
    freerun_word = 16'h2000; tick();
    check("R4 captured at entry", dco_word, 16'h1000);
    freq_err = 8'd20; tick(); check("R7 at threshold", lofl, 0);
    freq_err = 8'd21; tick(); check("R7 above threshold", lofl, 1);
    freq_err = 0; tick();
  endtask

  task automatic t_exit(logic [W-1:0] expw);
    ref_ok = 1; tick();
    check("R8 exit state", op_state, 1); check("R8 exit no step", dco_word, expw);
    check("R8 exit seed", lf_seed, 1);
    tick();
    check("R2 relock", op_state, 2); check("R8 word continues", dco_word, expw);
  endtask

  task automatic t_hold_mode1();
    sample(16'h1777);
    hold_mode = 1; ref_ok = 0; tick();
    check("R5 frozen lf word", dco_word, 16'h1777);
    sample(16'h1999);
    check("R9 ignored in holdover", dco_word, 16'h1777);
  endtask

  task automatic t_history();
    sample(16'd1000); sample(16'd1004); sample(16'd1008);
    check("R10 not yet valid", hist_valid, 0);
    sample(16'd1012);
    check("R10 valid after window", hist_valid, 1);
    sample(16'd2000); sample(16'd2000);
    hold_mode = 1; ref_ok = 0; tick();
    check("R3 history word", dco_word, 16'd1006);
    sample(16'd3000); tick();
    check("R11 word frozen", dco_word, 16'd1006);
    check("R11 hist kept", hist_valid, 1);
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_hold_mode0();
    t_exit(16'h1000);
    t_hold_mode1();
    t_exit(16'h1777);
    t_history();
    t_exit(16'd1006);
    check("R11 hist after exit", hist_valid, 1);
    do_reset();
    check("R1 reset clears hist", hist_valid, 0);
    check("R1 reset state", op_state, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule